// File: doc/BRIEF.md
# Port Status LED Driver

This block turns PHY status levels and MAC event pulses into active-low indicator LED outputs for a set of Ethernet ports (two by default). Each port drives four LEDs: a collision indicator, a combined duplex/collision indicator, a link/activity indicator and a link/receive indicator. Each LED follows its own rule. It is either steadily lit for a static condition, or it blinks while recent events are being shown.

The PHY link and duplex inputs are active-low levels. They pass through a two-flop synchroniser before any LED logic uses them. The MAC supplies single-cycle pulses for transmit, receive and collision events. Each pulse opens a display window of `FLASH_WIN` clock cycles for that port and event kind. A later pulse of the same kind restarts the window at its full length. While a window is open, the affected LED follows a shared blink phase. A free-running divider inside the block toggles that phase once every `FLASH_DIV` cycles.

Top module: `port_led_drv`

## Requirements
- R1: While reset is asserted and directly after it is released, every LED output is high (dark).
- R2: The link and duplex inputs are active-low (0 means link up and full duplex respectively). A change on them reaches the LEDs exactly two rising clock edges after it is applied.
- R3: With link up and full duplex, the duplex/collision LED is steadily low, whatever collision pulses arrive.
- R4: With link up and half duplex, the duplex/collision LED is dark unless a collision window is open. While the window is open it equals the inverted blink phase.
- R5: The collision LED is lit only in half duplex during an open collision window, in the lit blink phase. Link does not matter. In full duplex it stays dark.
- R6: With link up, the link/activity LED is steadily low when neither a transmit nor a receive window is open. While either window is open it follows the blink phase.
- R7: With link up, the link/receive LED is steadily low unless a receive window is open, in which case it follows the blink phase. Transmit pulses have no effect on it.
- R8: With link down, the duplex/collision, link/activity and link/receive LEDs stay dark, whatever events arrive.
- R9: A pulse sampled at a clock edge keeps its window open for exactly `FLASH_WIN` cycles after that edge. A pulse of the same kind arriving while the window is open restarts the full length.
- R10: The blink phase after n rising edges since reset release is floor(n / `FLASH_DIV`) mod 2. A flashing LED is lit (low) when this phase is 1.
- R11: Ports are independent: the inputs of one port never change the LEDs of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_n | input | NPORT | PHY link status per port, active low |
| fdx_n | input | NPORT | PHY full-duplex status per port, active low |
| tx_evt | input | NPORT | Single-cycle transmit event per port |
| rx_evt | input | NPORT | Single-cycle receive event per port |
| col_evt | input | NPORT | Single-cycle collision event per port |
| led_col_n | output | NPORT | Collision LED, active low |
| led_fdcol_n | output | NPORT | Duplex/collision LED, active low |
| led_lnact_n | output | NPORT | Link/activity LED, active low |
| led_lnrx_n | output | NPORT | Link/receive LED, active low |

## Verification
Some rules hold on every cycle and are checked by the embedded assertions. These are:
- the steady duplex/collision LED in full duplex;
- the dark collision LED in full duplex;
- the dark link-gated LEDs while link is down;
- the steady receive LED with no receive window open;
- the opening of a window on a pulse;
- the blink phase holding between divider wraps.

Other rules can only be shown by the bench's scenarios, which compare every LED against an independent model cycle by cycle. These are the two-edge synchroniser latency, the exact window length and its restart on retrigger, the blink phase arithmetic, and the independence of the ports.

// File: rtl/port_led_pkg.sv
package port_led_pkg;
  localparam int EV_TX  = 0;
  localparam int EV_RX  = 1;
  localparam int EV_COL = 2;
  localparam int EV_N   = 3;

  // flashing LED follows the blink phase while a window is open, else the idle value
  function automatic logic flash_sel(input logic act, input logic blink, input logic idle_val);
    return act ? blink : idle_val;
  endfunction
endpackage

// File: rtl/led_sync2.sv
module led_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      dout   <= '1;
    end else begin
      meta_q <= din;
      dout   <= meta_q;
    end
  end
endmodule

// File: rtl/led_blink_div.sv
module led_blink_div #(
  parameter int FLASH_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic blink,
  output logic wrap
);
  localparam int CW = (FLASH_DIV > 2) ? $clog2(FLASH_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(FLASH_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      blink <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      blink <= blink ^ wrap;
    end
  end

  AST_BLINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(blink)); // R10
endmodule

// File: rtl/led_flash_win.sv
module led_flash_win #(
  parameter int FLASH_WIN = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  output logic act
);
  localparam int CW = $clog2(FLASH_WIN + 1);
  localparam logic [CW-1:0] FULL = CW'(FLASH_WIN);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left_q <= '0;
    else if (evt)          left_q <= FULL;
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign act = (left_q != '0);

  AST_WIN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> act); // R9
  AST_WIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !act) |=> !act); // R9
endmodule

// File: rtl/port_led_drv.sv
module port_led_drv
  import port_led_pkg::*;
#(
  parameter int NPORT     = 2,
  parameter int FLASH_DIV = 1250000,
  parameter int FLASH_WIN = 5000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] link_n,
  input  logic [NPORT-1:0] fdx_n,
  input  logic [NPORT-1:0] tx_evt,
  input  logic [NPORT-1:0] rx_evt,
  input  logic [NPORT-1:0] col_evt,
  output logic [NPORT-1:0] led_col_n,
  output logic [NPORT-1:0] led_fdcol_n,
  output logic [NPORT-1:0] led_lnact_n,
  output logic [NPORT-1:0] led_lnrx_n
);
  localparam int SW = 2 * NPORT;

  logic [SW-1:0]         st_sync;
  logic                  blink;
  logic                  blink_wrap;
  logic [EV_N*NPORT-1:0] act_all;
  logic [NPORT-1:0]      link_up;
  logic [NPORT-1:0]      full_up;

  led_sync2 #(.W(SW)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .din ({fdx_n, link_n}),
    .dout (st_sync)
  );

  led_blink_div #(.FLASH_DIV(FLASH_DIV)) u_div (
    .clk (clk),
    .rst_n (rst_n),
    .blink (blink),
    .wrap (blink_wrap)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [EV_N-1:0] evt_k;
    logic tx_act, rx_act, col_act;
    logic col_lit, fd_lit, la_lit, lr_lit;

    assign evt_k = {col_evt[p], rx_evt[p], tx_evt[p]};

    for (genvar k = 0; k < EV_N; k++) begin : g_win
      led_flash_win #(.FLASH_WIN(FLASH_WIN)) u_win (
        .clk (clk),
        .rst_n (rst_n),
        .evt (evt_k[k]),
        .act (act_all[EV_N*p + k])
      );
    end

    assign tx_act  = act_all[EV_N*p + EV_TX];
    assign rx_act  = act_all[EV_N*p + EV_RX];
    assign col_act = act_all[EV_N*p + EV_COL];

    assign link_up[p] = ~st_sync[p];
    assign full_up[p] = ~st_sync[NPORT + p];

    assign col_lit = ~full_up[p] & flash_sel(col_act, blink, 1'b0);
    assign fd_lit  = link_up[p] & (full_up[p] | flash_sel(col_act, blink, 1'b0));
    assign la_lit  = link_up[p] & flash_sel(tx_act | rx_act, blink, 1'b1);
    assign lr_lit  = link_up[p] & flash_sel(rx_act, blink, 1'b1);

    assign led_col_n[p]   = ~col_lit;
    assign led_fdcol_n[p] = ~fd_lit;
    assign led_lnact_n[p] = ~la_lit;
    assign led_lnrx_n[p]  = ~lr_lit;

    AST_FULL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (link_up[p] && full_up[p]) |-> !led_fdcol_n[p]); // R3
    AST_COL_FULL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      full_up[p] |-> led_col_n[p]); // R5
    AST_DOWN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      !link_up[p] |-> (led_fdcol_n[p] && led_lnact_n[p] && led_lnrx_n[p])); // R8
    AST_RX_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (link_up[p] && !rx_act) |-> !led_lnrx_n[p]); // R7
  end
endmodule

// File: tb/port_led_drv_tb_top.sv
module port_led_drv_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 2;
  localparam int DIV = 4;
  localparam int WIN = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] link_n = '1, fdx_n = '1, tx_evt = '0, rx_evt = '0, col_evt = '0;
  logic [NP-1:0] led_col_n, led_fdcol_n, led_lnact_n, led_lnrx_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct { logic [4*NP-1:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  port_led_drv #(.NPORT(NP), .FLASH_DIV(DIV), .FLASH_WIN(WIN)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .link_n (link_n), .fdx_n (fdx_n),
    .tx_evt (tx_evt), .rx_evt (rx_evt), .col_evt (col_evt),
    .led_col_n (led_col_n), .led_fdcol_n (led_fdcol_n),
    .led_lnact_n (led_lnact_n), .led_lnrx_n (led_lnrx_n)
  );

  // reference model state: edge count, two-stage status history, last event edge
  int n_edge;
  logic [NP-1:0] l1, l2, f1, f2;
  int last_tx[NP], last_rx[NP], last_col[NP];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_edge = 0;
      l1 = '1; l2 = '1; f1 = '1; f2 = '1;
      for (int p = 0; p < NP; p++) begin
        last_tx[p] = -1000; last_rx[p] = -1000; last_col[p] = -1000;
      end
    end else begin
      n_edge = n_edge + 1;
      l2 = l1; l1 = link_n;
      f2 = f1; f1 = fdx_n;
      for (int p = 0; p < NP; p++) begin
        if (tx_evt[p])  last_tx[p]  = n_edge;
        if (rx_evt[p])  last_rx[p]  = n_edge;
        if (col_evt[p]) last_col[p] = n_edge;
      end
    end
  end

  function automatic logic open_win(int last);
    return (n_edge - last) < WIN;
  endfunction

  function automatic logic [4*NP-1:0] model_leds();
    logic [NP-1:0] c, fd, la, lr;
    logic ph;
    ph = ((n_edge / DIV) % 2) == 1;
    for (int p = 0; p < NP; p++) begin
      logic up, full, ca, ta, ra;
      up = !l2[p]; full = !f2[p];
      ca = open_win(last_col[p]); ta = open_win(last_tx[p]); ra = open_win(last_rx[p]);
      c[p]  = !full && ca && ph;
      fd[p] = up && (full || (ca && ph));
      la[p] = up && ((ta || ra) ? ph : 1'b1);
      lr[p] = up && (ra ? ph : 1'b1);
    end
    return ~{c, fd, la, lr};
  endfunction

  // driver side: queue the expectation for the coming negedge
  task automatic run_chk(int ncyc, string tag);
    for (int i = 0; i < ncyc; i++) begin
      item_t it;
      @(posedge clk); #1;
      it.exp = model_leds();
      it.tag = tag;
      sb_q.push_back(it);
    end
  endtask

  task automatic pulse(int p, int kind, string tag);
    @(posedge clk); #1;
    case (kind)
      0: tx_evt[p] = 1'b1;
      1: rx_evt[p] = 1'b1;
      default: col_evt[p] = 1'b1;
    endcase
    run_chk(1, tag);
    tx_evt = '0; rx_evt = '0; col_evt = '0;
  endtask

  // monitor: compare against design at negedge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [4*NP-1:0] act;
      it = sb_q.pop_front();
      act = {led_col_n, led_fdcol_n, led_lnact_n, led_lnrx_n};
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s at edge %0d: actual=%b expected=%b", it.tag, n_edge, act, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: dark during and after reset
    #(CLK_PERIOD * 3);
    checks++;
    if ({led_col_n, led_fdcol_n, led_lnact_n, led_lnrx_n} !== '1) begin
      failures++;
      $display("FAIL R1 in reset: actual=%b expected=all ones",
               {led_col_n, led_fdcol_n, led_lnact_n, led_lnrx_n});
    end
    @(posedge clk); #1; rst_n = 1'b1;
    run_chk(5, "R1");

    // R2: port0 link up, full duplex; two-edge latency
    @(posedge clk); #1; link_n[0] = 1'b0; fdx_n[0] = 1'b0;
    run_chk(4, "R2");

    // R3: collisions ignored on duplex LED in full duplex, col LED dark (R5)
    pulse(0, 2, "R3");
    run_chk(16, "R3");

    // R4 / R5: half duplex collisions flash
    @(posedge clk); #1; fdx_n[0] = 1'b1;
    run_chk(3, "R4");
    pulse(0, 2, "R4");
    run_chk(16, "R5");

    // R6: transmit activity
    pulse(0, 0, "R6");
    run_chk(16, "R6");

    // R7: receive activity; tx alone leaves the rx LED steady
    pulse(0, 1, "R7");
    run_chk(16, "R7");

    // R9: retrigger restarts the full window
    pulse(0, 1, "R9");
    run_chk(7, "R9");
    pulse(0, 1, "R9");
    run_chk(16, "R9");

    // R10: steady stream of receive pulses spanning several blink periods
    for (int j = 0; j < 5; j++) begin
      pulse(0, 1, "R10");
      run_chk(4, "R10");
    end

    // R8: link down, all events; R5 collision still flashes in half duplex
    @(posedge clk); #1; link_n[0] = 1'b1;
    run_chk(3, "R8");
    pulse(0, 0, "R8");
    pulse(0, 1, "R8");
    pulse(0, 2, "R5");
    run_chk(16, "R8");

    // R11: port1 up in full duplex, events on port0 only
    @(posedge clk); #1; link_n[1] = 1'b0; fdx_n[1] = 1'b0; link_n[0] = 1'b0;
    run_chk(3, "R11");
    pulse(0, 1, "R11");
    pulse(0, 2, "R11");
    run_chk(10, "R11");
    pulse(1, 0, "R11");
    run_chk(16, "R11");

    @(posedge clk); #1;
    @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule